// File: doc/BRIEF.md
# Bus Slave Window Address Translator

The block decides whether an incoming bus address falls inside one of four software-programmed slave windows. For a matching window it forms a local address by adding that window's translation offset. Each window has four registers: an enable word, a start page, an end page and an offset page. The windows work at 64 KB granularity. A single global response-enable bit must also be set before any window can answer.

Software reaches the registers through a small synchronous register port, and changes may be made while lookups run. The register file is little-endian. A word presented on the register port is byte-reversed before its fields are interpreted, and it is byte-reversed again when read back. The lookup side takes an address with a valid strobe. One clock later it returns a hit flag, the winning window number and the translated address. The surrounding bus logic uses these to claim the cycle and steer it into local memory.

Top module: `swin_xlate`

## Requirements
- R1: After reset every register reads zero and lk_hit, lk_win and lk_xaddr are zero, so no window and no global enable is active.
- R2: Register offsets (byte addresses):
  - The global enable word is at 0x004.
  - Window n occupies a block at 0xF00 + 0x14*n. Its enable word is at +0x0, its start page at +0x4, its end page at +0x8 and its offset page at +0xC.
  - A write stores the byte-reversed value of reg_wdata.
  - reg_rdata shows the byte-reversed stored value of the word addressed in the previous cycle.
- R3: Only these field bits are kept, and all other bits read back zero:
  - Enable word: interpreted bit 31 (bus bit 7, 0x00000080).
  - Start, end and offset pages: interpreted bits 31:16 (bus bits 15:0).
  - Global enable word: interpreted bit 2 (bus bit 26, 0x04000000).
  - Any offset outside the map reads zero, and a write to it changes nothing.
- R4: A valid lookup hits window n when the global enable is set, n's enable bit is set, and start <= addr[31:16] < end.
- R5: A window whose end page is at or below its start page never hits.
- R6: With the global enable clear, no lookup hits, whatever the window settings.
- R7: When several windows hit, the lowest-numbered one is reported.
- R8: On a hit, lk_xaddr equals lk_addr + (offset page << 16) modulo 2^32, so the low 16 address bits pass unchanged.
- R9: The lookup result appears one cycle after lk_valid. In the cycle after lk_valid is low, or after a valid lookup that misses, lk_hit, lk_win and lk_xaddr are all zero.
- R10: A register write takes effect for the next lookup cycle. A lookup presented in the same cycle as a write still sees the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data, bus byte order |
| reg_rdata | output | 32 | Register read data, bus byte order, one cycle after reg_addr |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Incoming bus address |
| lk_hit | output | 1 | A window claimed the previous lookup |
| lk_win | output | 2 | Number of the winning window |
| lk_xaddr | output | 32 | Translated local address |

## Verification
Lookups sweep the whole upper-address space in fine steps, and every window's start-1, start, end-1 and end pages are added to the sweep. This separates an off-by-one at either edge from a wrong compare direction. Three arrangements are used:
- a single window, with the global enable first clear and then set;
- overlapping windows, one empty window, one inverted window and an offset that wraps past 2^32, which together exercise priority, empty ranges and modular addition;
- four identical windows, with the lowest ones then switched off in turn, which exposes a reversed priority encoder.

Register readback after all-ones writes shows the byte order and the masking. A write and a lookup in the same cycle separate an early-applied write from a late one.

// File: rtl/swin_pkg.sv
package swin_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int PAGE_W = 16;
    localparam int LOW_W  = ADDR_W - PAGE_W;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic  en;
        page_t base;
        page_t bound;
        page_t off;
    } win_cfg_t;

    function automatic logic [DATA_W-1:0] bswap32(input logic [DATA_W-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/swin_regfile.sv
module swin_regfile
    import swin_pkg::*;
#(
    parameter int NWIN       = 4,
    parameter int REG_AW     = 12,
    parameter int WIN_BASE   = 'hF00,
    parameter int WIN_STRIDE = 'h014,
    parameter int CSR_OFF    = 'h004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic                    reg_we,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output win_cfg_t [NWIN-1:0]     cfg_o,
    output logic                    glob_en_o
);

    localparam int PAD_W = DATA_W - PAGE_W;

    typedef struct packed {
        win_cfg_t [NWIN-1:0] cfg;
        logic                gen;
        logic [DATA_W-1:0]   rdata;
    } rf_state_t;

    rf_state_t s_d, s_q;
    logic [DATA_W-1:0] wv;
    logic [DATA_W-1:0] rd_val;
    logic              csr_sel;

    assign wv      = bswap32(reg_wdata);
    assign csr_sel = (int'(reg_addr) == CSR_OFF);

    always_comb begin
        int blk;
        s_d    = s_q;
        rd_val = '0;
        if (csr_sel) begin
            rd_val = {{(DATA_W-3){1'b0}}, s_q.gen, 2'b00};
            if (reg_we) s_d.gen = wv[2];
        end
        for (int w = 0; w < NWIN; w++) begin
            blk = WIN_BASE + w * WIN_STRIDE;
            if (int'(reg_addr) == blk) begin
                rd_val = {s_q.cfg[w].en, {(DATA_W-1){1'b0}}};
                if (reg_we) s_d.cfg[w].en = wv[DATA_W-1];
            end
            if (int'(reg_addr) == blk + 4) begin
                rd_val = {s_q.cfg[w].base, {PAD_W{1'b0}}};
                if (reg_we) s_d.cfg[w].base = wv[DATA_W-1 -: PAGE_W];
            end
            if (int'(reg_addr) == blk + 8) begin
                rd_val = {s_q.cfg[w].bound, {PAD_W{1'b0}}};
                if (reg_we) s_d.cfg[w].bound = wv[DATA_W-1 -: PAGE_W];
            end
            if (int'(reg_addr) == blk + 12) begin
                rd_val = {s_q.cfg[w].off, {PAD_W{1'b0}}};
                if (reg_we) s_d.cfg[w].off = wv[DATA_W-1 -: PAGE_W];
            end
        end
        s_d.rdata = bswap32(rd_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.rdata;
    assign cfg_o     = s_q.cfg;
    assign glob_en_o = s_q.gen;

    // R10: a global enable write is visible on the following cycle
    p_csr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && csr_sel) |=> (glob_en_o == $past(wv[2])));

    // R3: reading the global enable word shows nothing but its one bit
    p_csr_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_sel |=> ((reg_rdata & ~32'h0400_0000) == '0));

    for (genvar g = 0; g < NWIN; g++) begin : g_wchk
        // R10: a window enable write is visible on the following cycle
        p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && int'(reg_addr) == WIN_BASE + g * WIN_STRIDE)
            |=> (cfg_o[g].en == $past(wv[DATA_W-1])));
    end

endmodule

// File: rtl/swin_match.sv
module swin_match
    import swin_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_cfg_t [NWIN-1:0] cfg_i,
    input  logic                glob_en_i,
    input  page_t               page_i,
    output logic [NWIN-1:0]     hitv_o
);

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        logic lo_ok;
        logic hi_ok;
        assign lo_ok     = (page_i >= cfg_i[g].base);
        assign hi_ok     = (page_i <  cfg_i[g].bound);
        assign hitv_o[g] = glob_en_i & cfg_i[g].en & lo_ok & hi_ok;
    end

endmodule

// File: rtl/swin_pick.sv
module swin_pick
    import swin_pkg::*;
#(
    parameter int NWIN = 4,
    parameter int WIDX = $clog2(NWIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic [NWIN-1:0]     hitv_i,
    input  logic                glob_en_i,
    input  win_cfg_t [NWIN-1:0] cfg_i,
    output logic                hit_o,
    output logic [WIDX-1:0]     win_o,
    output logic [ADDR_W-1:0]   xaddr_o
);

    typedef struct packed {
        logic              hit;
        logic [WIDX-1:0]   win;
        logic [ADDR_W-1:0] xaddr;
    } pk_state_t;

    pk_state_t p_d, p_q;
    logic [WIDX-1:0] sel;
    page_t           up;

    always_comb begin
        sel = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hitv_i[w]) sel = w[WIDX-1:0];
        end
        up  = lk_addr[ADDR_W-1 -: PAGE_W] + cfg_i[sel].off;
        p_d = '0;
        if (lk_valid && (|hitv_i)) begin
            p_d.hit   = 1'b1;
            p_d.win   = sel;
            p_d.xaddr = {up, lk_addr[LOW_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign hit_o   = p_q.hit;
    assign win_o   = p_q.win;
    assign xaddr_o = p_q.xaddr;

    // R9: without a request the outputs go quiet one cycle later
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!hit_o && win_o == '0 && xaddr_o == '0));

    // R6: global enable clear means no hit
    p_no_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |=> !hit_o);

    // R7: window 0 matching always wins
    p_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && hitv_i[0]) |=> (hit_o && win_o == '0));

    // R8: low address bits pass through on a hit
    p_low_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!hit_o || xaddr_o[LOW_W-1:0] == $past(lk_addr[LOW_W-1:0])));

endmodule

// File: rtl/swin_xlate.sv
module swin_xlate
    import swin_pkg::*;
#(
    parameter int NWIN       = 4,
    parameter int REG_AW     = 12,
    parameter int WIN_BASE   = 'hF00,
    parameter int WIN_STRIDE = 'h014,
    parameter int CSR_OFF    = 'h004,
    parameter int WIDX       = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WIDX-1:0]   lk_win,
    output logic [ADDR_W-1:0] lk_xaddr
);

    win_cfg_t [NWIN-1:0] cfg;
    logic                gen;
    logic [NWIN-1:0]     hitv;

    swin_regfile #(
        .NWIN(NWIN), .REG_AW(REG_AW), .WIN_BASE(WIN_BASE),
        .WIN_STRIDE(WIN_STRIDE), .CSR_OFF(CSR_OFF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_o(cfg), .glob_en_o(gen)
    );

    swin_match #(.NWIN(NWIN)) u_match (
        .cfg_i(cfg), .glob_en_i(gen),
        .page_i(lk_addr[ADDR_W-1 -: PAGE_W]), .hitv_o(hitv)
    );

    swin_pick #(.NWIN(NWIN), .WIDX(WIDX)) u_pick (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .hitv_i(hitv), .glob_en_i(gen), .cfg_i(cfg),
        .hit_o(lk_hit), .win_o(lk_win), .xaddr_o(lk_xaddr)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_empty
        // R5: an empty or inverted range never matches
        p_empty_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].bound <= cfg[g].base) |-> !hitv[g]);
    end

endmodule

// File: tb/swin_xlate_test.sv
module swin_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        lk_hit;
    logic [1:0]  lk_win;
    logic [31:0] lk_xaddr;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit done  = 0;

    bit          m_gen;
    bit          m_en[4];
    logic [15:0] m_base[4];
    logic [15:0] m_bound[4];
    logic [15:0] m_off[4];

    always #10 clk = ~clk;

    swin_xlate uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_win(lk_win), .lk_xaddr(lk_xaddr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog R9 act=timeout exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [31:0] sw(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [11:0] wreg(input int w, input int k);
        return 12'(32'hF00 + w * 32'h14 + k * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_bus(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp_bus, input string tag);
        reg_addr = a; reg_we = 1'b0;
        @(negedge clk);
        chk(tag, reg_rdata, exp_bus);
    endtask

    task automatic set_gen(input bit g);
        wr_bus(12'h004, sw({29'b0, g, 2'b0}));
        m_gen = g;
    endtask

    task automatic set_win(input int w, input bit en, input logic [15:0] b,
                           input logic [15:0] e, input logic [15:0] o);
        wr_bus(wreg(w, 0), sw({en, 31'b0}));
        wr_bus(wreg(w, 1), sw({b, 16'h0}));
        wr_bus(wreg(w, 2), sw({e, 16'h0}));
        wr_bus(wreg(w, 3), sw({o, 16'h0}));
        m_en[w] = en; m_base[w] = b; m_bound[w] = e; m_off[w] = o;
    endtask

    task automatic expect_look(input logic [31:0] a, output bit h,
                               output logic [1:0] wi, output logic [31:0] x);
        h = 0; wi = 0; x = 0;
        for (int w = 3; w >= 0; w--) begin
            if (m_gen && m_en[w] && a[31:16] >= m_base[w] && a[31:16] < m_bound[w]) begin
                h = 1; wi = 2'(w); x = a + {m_off[w], 16'h0};
            end
        end
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        bit          eh;
        logic [1:0]  ew;
        logic [31:0] ex;
        expect_look(a, eh, ew, ex);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " hit"},   {31'b0, lk_hit}, {31'b0, eh});
        chk({tag, " win"},   {30'b0, lk_win}, {30'b0, ew});
        chk({tag, " xaddr"}, lk_xaddr, ex);
    endtask

    task automatic sweep(input string tag);
        logic [31:0] lo;
        for (int p = 0; p < 65536; p += 29) begin
            lo = 32'(p) * 32'h9E37_79B1;
            look({p[15:0], lo[31:16]}, tag);
        end
        for (int w = 0; w < 4; w++) begin
            look({m_base[w] - 16'd1, 16'hFFFF}, {tag, " edge"});
            look({m_base[w], 16'h0000}, {tag, " edge"});
            look({m_bound[w] - 16'd1, 16'hFFFF}, {tag, " edge"});
            look({m_bound[w], 16'h0000}, {tag, " edge"});
        end
    endtask

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        lk_valid = 1'b0; lk_addr = '0;
        m_gen = 0;
        for (int w = 0; w < 4; w++) begin
            m_en[w] = 0; m_base[w] = 0; m_bound[w] = 0; m_off[w] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset hit", {31'b0, lk_hit}, 32'h0);
        chk("R1 reset xaddr", lk_xaddr, 32'h0);
        chk("R1 reset rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(12'h004, 32'h0, "R1 csr after reset");
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++)
                rd_chk(wreg(w, k), 32'h0, "R1 window reg after reset");

        // R2 / R3: byte order and field masking with all-ones writes
        wr_bus(12'h004, 32'hFFFF_FFFF);
        rd_chk(12'h004, 32'h0400_0000, "R3 csr mask");
        wr_bus(wreg(2, 0), 32'hFFFF_FFFF);
        rd_chk(wreg(2, 0), 32'h0000_0080, "R3 ctl mask");
        wr_bus(wreg(2, 1), 32'hFFFF_FFFF);
        rd_chk(wreg(2, 1), 32'h0000_FFFF, "R3 base mask");
        wr_bus(wreg(2, 3), 32'h1234_5678);
        rd_chk(wreg(2, 3), 32'h0000_5678, "R2 offset byte order");
        wr_bus(wreg(1, 1), 32'h0000_0008);
        rd_chk(wreg(1, 1), 32'h0000_0008, "R2 window1 base at 0xF14+4");
        wr_bus(12'hF10, 32'hFFFF_FFFF);
        rd_chk(12'hF10, 32'h0, "R3 gap offset reads zero");
        wr_bus(12'h000, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h0, "R3 unmapped offset reads zero");
        rd_chk(wreg(0, 0), 32'h0, "R3 unmapped write left window0 ctl alone");
        rd_chk(wreg(3, 3), 32'h0, "R3 unmapped write left window3 offset alone");

        // R6: single window, global enable off
        set_win(0, 0, 16'h0, 16'h0, 16'h0);
        set_win(1, 1, 16'h0800, 16'h0900, 16'h7800);
        set_win(2, 0, 16'h0, 16'h0, 16'h0);
        set_win(3, 0, 16'h0, 16'h0, 16'h0);
        set_gen(0);
        look(32'h0800_1234, "R6 global off");
        look(32'h08FF_FFFF, "R6 global off");
        set_gen(1);
        look(32'h0800_1234, "R8 example mapping");
        sweep("R4 single window");

        // R5 / R7 / R8: overlap, empty, inverted, wrap
        set_win(0, 1, 16'h1000, 16'h2000, 16'h0100);
        set_win(1, 1, 16'h1800, 16'h3000, 16'hF000);
        set_win(2, 1, 16'h4000, 16'h4000, 16'h0001);
        set_win(3, 1, 16'h6000, 16'h5000, 16'h0002);
        look(32'h4000_0000, "R5 empty window");
        look(32'h5800_0000, "R5 inverted window");
        look(32'h1900_ABCD, "R7 overlap low wins");
        look(32'h2800_0001, "R8 wrap offset");
        sweep("R4 overlap set");

        // R7: identical windows
        for (int w = 0; w < 4; w++) set_win(w, 1, 16'hA000, 16'hB000, 16'(w * 16'h111));
        sweep("R7 four equal");
        set_win(0, 0, 16'hA000, 16'hB000, 16'h0);
        look(32'hA123_4567, "R7 window1 next");
        set_win(1, 0, 16'hA000, 16'hB000, 16'h111);
        look(32'hA123_4567, "R7 window2 next");

        // R9: idle request and miss
        lk_valid = 1'b0; lk_addr = 32'hA500_0000;
        @(negedge clk);
        chk("R9 idle hit", {31'b0, lk_hit}, 32'h0);
        chk("R9 idle win", {30'b0, lk_win}, 32'h0);
        chk("R9 idle xaddr", lk_xaddr, 32'h0);
        look(32'h0000_0010, "R9 miss zeros");

        // R10: write and lookup in the same cycle
        set_win(0, 1, 16'h2000, 16'h2100, 16'h0);
        set_win(1, 0, 16'h0, 16'h0, 16'h0);
        set_win(2, 0, 16'h0, 16'h0, 16'h0);
        set_win(3, 0, 16'h0, 16'h0, 16'h0);
        reg_addr = wreg(0, 0); reg_we = 1'b1; reg_wdata = 32'h0;
        lk_valid = 1'b1; lk_addr = 32'h2000_0040;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R10 same cycle uses old", {31'b0, lk_hit}, 32'h1);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R10 next cycle uses new", {31'b0, lk_hit}, 32'h0);
        m_en[0] = 0;
        set_win(0, 1, 16'h2000, 16'h2100, 16'h0);
        look(32'h2000_0040, "R10 re-enabled");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule